// File: doc/BRIEF.md
# Power and Sleep Controller Register Block

This block lets software move a small set of peripheral modules between four power/clock states and switch the power domains those modules sit in. Software programs a requested state into each module's control word through a simple 32-bit register write/read port. Nothing happens to a module on that write alone. A later write to the transition command register starts a sequence for the chosen domain, and the requested states are then applied to every module of that domain after a fixed number of cycles. Each module has a clock-enable output and an active-low reset output. Each domain has a power-request output that tells an external power switch to turn the domain on.

When the command targets a domain that is off and whose requested power state is on, the domain sequencer raises the domain's pending bit and its power-request output, then waits. Software acknowledges by setting the power-good bit in the domain control word, and the sequence then goes on. A force bit in any module control word of that domain lets the sequence skip that wait. Module m belongs to domain m modulo the domain count. The sequencer states are IDLE, WAIT_PWR (waiting for power good), RUN (counting the transition cycles) and FINISH (a one-cycle closing step used when no module changes). Its transitions are:
- IDLE to WAIT_PWR, on a command when the domain is off and requested on.
- IDLE to RUN, on a command with at least one module change.
- IDLE to FINISH, on a command with no module change.
- WAIT_PWR to RUN or FINISH, on power good or force.
- RUN to IDLE, when the count expires.
- FINISH to IDLE, always.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, every module status reads 0x2 (disabled) and every module control reads 0x102 (next state 2, local reset released, force clear). Every domain status reads 1 (on) and every domain control reads 1. The transition status and pending registers read 0, and all clock-enable and power-request outputs are low.
- R2: The registers are decoded only at word-aligned addresses: pending 0x070, command 0x120 (reads 0), transition status 0x128, domain status 0x200+4n, domain control 0x300+4n, module status 0x800+4n and module control 0xA00+4n. Any other address reads 0 and ignores writes, and so does an index beyond the module or domain count. Writes to the status registers have no effect.
- R3: The module control write stores the next state from bits [1:0]; bits [5:2] read back 0. Module status bits [5:0] do not change on that write. After a command written at clock edge k that starts RUN, every module of the domain takes its requested state at edge k+TRANS_CYC. Modules of other domains keep their state.
- R4: Bit n of transition status is 1 from the edge that accepts a command for domain n until the sequence ends. A command with no module change and no power-up reads busy for exactly one cycle.
- R5: A module's clock-enable output and its status bit 12 are 1 only while its current state is 3 (enabled).
- R6: Module control bit 8 is an active-low local reset. A module's reset output is high only when bit 8 is 1 and its current state is 2 or 3. States 0 and 1 hold the module in reset whatever bit 8 holds.
- R7: A command for a domain that is off and requested on (domain control bit 0 = 1) sets pending bit n and power-request n. Both stay high until domain control bit 8 (power good) reads 1. On the edge after that, the domain status becomes 1 and the sequence continues.
- R8: If any module control word in the waiting domain has bit 31 (force) set, the sequence leaves the wait on the next edge without power good.
- R9: A sequence that ends while the domain's requested power state is 0 leaves the domain status at 0.
- R10: A command written to a domain that is already busy is ignored; it neither restarts nor extends the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module active-low reset |
| pwr_req | output | N_DOM | Per-domain request to the external power switch |

## Verification
A sequencer that is stuck in the wrong state shows at the ports in one of two ways. Transition status can stay high past the expected edge. A pending bit can also fail to drop on the edge after power good. Both appear within one cycle of the point where the reference model diverges. A wrong module state becomes visible at once on the clock-enable and reset outputs, and the model compares those on every cycle. A counter that is off by one moves the status change by one edge. The bench catches this by reading module status exactly on the edges before and after k+TRANS_CYC.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        MST_SWRSTDIS = 2'd0,
        MST_SYNCRST  = 2'd1,
        MST_DISABLE  = 2'd2,
        MST_ENABLE   = 2'd3
    } mod_state_e;

    typedef enum logic [1:0] {
        DS_IDLE     = 2'd0,
        DS_WAIT_PWR = 2'd1,
        DS_RUN      = 2'd2,
        DS_FINISH   = 2'd3
    } dom_state_e;

    localparam logic [11:0] OFS_PEND = 12'h070;
    localparam logic [11:0] OFS_CMD  = 12'h120;
    localparam logic [11:0] OFS_BUSY = 12'h128;
    localparam logic [3:0]  PG_DSTAT = 4'h2;
    localparam logic [3:0]  PG_DCTL  = 4'h3;
    localparam logic [3:0]  PG_MSTAT = 4'h8;
    localparam logic [3:0]  PG_MCTL  = 4'hA;

endpackage

// File: rtl/pws_mod_slot.sv
module pws_mod_slot
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctl,
    input  logic [1:0] wr_next,
    input  logic       wr_lrst_n,
    input  logic       wr_force,
    input  logic       apply,
    output logic [1:0] cur_state,
    output logic [1:0] ctl_next,
    output logic       ctl_lrst_n,
    output logic       ctl_force,
    output logic       differs,
    output logic       clk_en,
    output logic       rst_out_n
);

    mod_state_e state_q;
    mod_state_e next_q;
    logic       lrst_q;
    logic       force_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MST_DISABLE;
            next_q  <= MST_DISABLE;
            lrst_q  <= 1'b1;
            force_q <= 1'b0;
        end else begin
            if (apply) begin
                state_q <= next_q;
            end
            if (wr_ctl) begin
                next_q  <= mod_state_e'(wr_next);
                lrst_q  <= wr_lrst_n;
                force_q <= wr_force;
            end
        end
    end

    always_comb begin
        cur_state  = state_q;
        ctl_next   = next_q;
        ctl_lrst_n = lrst_q;
        ctl_force  = force_q;
        differs    = (state_q != next_q);
        clk_en     = (state_q == MST_ENABLE);
        unique case (state_q)
            MST_SWRSTDIS, MST_SYNCRST: rst_out_n = 1'b0;
            MST_DISABLE, MST_ENABLE:   rst_out_n = lrst_q;
        endcase
    end

endmodule

// File: rtl/pws_dom_seq.sv
module pws_dom_seq
    import pwr_sleep_pkg::*;
#(
    parameter int TRANS_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctl,
    input  logic wr_next,
    input  logic wr_good,
    input  logic cmd,
    input  logic any_change,
    input  logic any_force,
    output logic apply,
    output logic busy,
    output logic pending,
    output logic pd_on,
    output logic ctl_next,
    output logic ctl_good
);

    localparam int CNT_W = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRANS_CYC - 1);

    dom_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             on_q, next_q, good_q;
    logic             go_pwr;

    // state register and the registers it steers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            cnt_q   <= '0;
            on_q    <= 1'b1;
            next_q  <= 1'b1;
            good_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (go_pwr) begin
                on_q <= 1'b1;
            end else if (apply && !next_q) begin
                on_q <= 1'b0;
            end
            if (wr_ctl) begin
                next_q <= wr_next;
                good_q <= wr_good;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        go_pwr  = 1'b0;
        unique case (state_q)
            DS_IDLE: begin
                if (cmd) begin
                    if (!on_q && next_q) begin
                        state_d = DS_WAIT_PWR;
                    end else if (any_change) begin
                        state_d = DS_RUN;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = DS_FINISH;
                    end
                end
            end
            DS_WAIT_PWR: begin
                if (good_q || any_force) begin
                    go_pwr = 1'b1;
                    if (any_change) begin
                        state_d = DS_RUN;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = DS_FINISH;
                    end
                end
            end
            DS_RUN: begin
                if (cnt_q == '0) begin
                    state_d = DS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            DS_FINISH: begin
                state_d = DS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        apply    = 1'b0;
        busy     = 1'b1;
        pending  = 1'b0;
        unique case (state_q)
            DS_IDLE:     busy    = 1'b0;
            DS_WAIT_PWR: pending = 1'b1;
            DS_RUN:      apply   = (cnt_q == '0);
            DS_FINISH:   apply   = 1'b1;
        endcase
        pd_on    = on_q;
        ctl_next = next_q;
        ctl_good = good_q;
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int N_MOD     = 4,
    parameter int N_DOM     = 2,
    parameter int TRANS_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [N_MOD-1:0] mod_clk_en,
    output logic [N_MOD-1:0] mod_rst_n,
    output logic [N_DOM-1:0] pwr_req
);

    localparam int MI_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;
    localparam int DI_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    logic [3:0]      page;
    logic [5:0]      word_idx;
    logic            aligned;
    logic            in_dom, in_mod;
    logic [MI_W-1:0] idx_m;
    logic [DI_W-1:0] idx_d;
    logic            unused_wdata;

    logic [N_MOD-1:0][1:0] mod_state;
    logic [N_MOD-1:0][1:0] mod_next;
    logic [N_MOD-1:0]      mod_lrst_n;
    logic [N_MOD-1:0]      mod_force;
    logic [N_MOD-1:0]      mod_diff;
    logic [N_MOD-1:0]      mod_apply;

    logic [N_DOM-1:0] dom_apply, dom_busy, dom_pend, dom_on;
    logic [N_DOM-1:0] dom_next, dom_good, dom_change, dom_force;

    assign page         = bus_addr[11:8];
    assign word_idx     = bus_addr[7:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign in_dom       = (int'(word_idx) < N_DOM);
    assign in_mod       = (int'(word_idx) < N_MOD);
    assign idx_m        = bus_addr[2 +: MI_W];
    assign idx_d        = bus_addr[2 +: DI_W];
    assign unused_wdata = ^bus_wdata;

    // group module change/force flags per domain (module m lives in domain m % N_DOM)
    always_comb begin
        dom_change = '0;
        dom_force  = '0;
        for (int d = 0; d < N_DOM; d++) begin
            for (int m = 0; m < N_MOD; m++) begin
                if ((m % N_DOM) == d) begin
                    dom_change[d] = dom_change[d] | mod_diff[m];
                    dom_force[d]  = dom_force[d]  | mod_force[m];
                end
            end
        end
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        logic wr_m;
        assign wr_m         = bus_wr && aligned && (page == PG_MCTL) && (int'(word_idx) == m);
        assign mod_apply[m] = dom_apply[m % N_DOM];

        pws_mod_slot slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctl     (wr_m),
            .wr_next    (bus_wdata[1:0]),
            .wr_lrst_n  (bus_wdata[8]),
            .wr_force   (bus_wdata[31]),
            .apply      (mod_apply[m]),
            .cur_state  (mod_state[m]),
            .ctl_next   (mod_next[m]),
            .ctl_lrst_n (mod_lrst_n[m]),
            .ctl_force  (mod_force[m]),
            .differs    (mod_diff[m]),
            .clk_en     (mod_clk_en[m]),
            .rst_out_n  (mod_rst_n[m])
        );
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic wr_d, cmd_d;
        assign wr_d  = bus_wr && aligned && (page == PG_DCTL) && (int'(word_idx) == d);
        assign cmd_d = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[d];

        pws_dom_seq #(.TRANS_CYC(TRANS_CYC)) seq_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctl     (wr_d),
            .wr_next    (bus_wdata[0]),
            .wr_good    (bus_wdata[8]),
            .cmd        (cmd_d),
            .any_change (dom_change[d]),
            .any_force  (dom_force[d]),
            .apply      (dom_apply[d]),
            .busy       (dom_busy[d]),
            .pending    (dom_pend[d]),
            .pd_on      (dom_on[d]),
            .ctl_next   (dom_next[d]),
            .ctl_good   (dom_good[d])
        );
    end

    assign pwr_req = dom_pend;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bus_addr == OFS_PEND) begin
                bus_rdata[N_DOM-1:0] = dom_pend;
            end else if (bus_addr == OFS_BUSY) begin
                bus_rdata[N_DOM-1:0] = dom_busy;
            end else begin
                case (page)
                    PG_DSTAT: if (in_dom) bus_rdata[0] = dom_on[idx_d];
                    PG_DCTL:  if (in_dom) begin
                        bus_rdata[0] = dom_next[idx_d];
                        bus_rdata[8] = dom_good[idx_d];
                    end
                    PG_MSTAT: if (in_mod) begin
                        bus_rdata[1:0] = mod_state[idx_m];
                        bus_rdata[12]  = mod_clk_en[idx_m];
                    end
                    PG_MCTL:  if (in_mod) begin
                        bus_rdata[1:0] = mod_next[idx_m];
                        bus_rdata[8]   = mod_lrst_n[idx_m];
                        bus_rdata[31]  = mod_force[idx_m];
                    end
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pws_ctrl_chk.sv
module pws_ctrl_chk #(
    parameter int N_MOD = 4,
    parameter int N_DOM = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_MOD-1:0]      mod_clk_en,
    input logic [N_MOD-1:0]      mod_rst_n,
    input logic [N_DOM-1:0]      pwr_req,
    input logic [N_DOM-1:0]      dom_busy,
    input logic [N_DOM-1:0]      dom_apply,
    input logic [N_DOM-1:0]      dom_good,
    input logic [N_DOM-1:0]      dom_force,
    input logic [N_MOD-1:0][1:0] mod_state,
    input logic [N_MOD-1:0]      mod_lrst_n
);

    for (genvar d = 0; d < N_DOM; d++) begin : g_d
        // R7
        pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_req[d] |-> dom_busy[d]);
        // R7
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_req[d] && !dom_good[d] && !dom_force[d]) |=> pwr_req[d]);
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_m
        // R3
        state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dom_apply[m % N_DOM] |=> $stable(mod_state[m]));
        // R5
        clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mod_clk_en[m]) |-> $past(dom_apply[m % N_DOM]));
        // R6
        lrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mod_lrst_n[m] |-> !mod_rst_n[m]);
    end

endmodule

bind pwr_sleep_ctrl pws_ctrl_chk #(.N_MOD(N_MOD), .N_DOM(N_DOM)) chk_i (.*);

// File: tb/pwr_sleep_ctrl_tb_top.sv
module pwr_sleep_ctrl_tb_top;

    localparam int NM = 4;
    localparam int ND = 2;
    localparam int TC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NM-1:0] mod_clk_en, mod_rst_n;
    logic [ND-1:0] pwr_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_sleep_ctrl #(.N_MOD(NM), .N_DOM(ND), .TRANS_CYC(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_clk_en(mod_clk_en),
        .mod_rst_n(mod_rst_n), .pwr_req(pwr_req));

    // ---------------- reference model ----------------
    int m_nxt[NM], m_cur[NM], m_lr[NM], m_fr[NM];
    int d_mode[ND], d_cnt[ND], d_on[ND], d_pn[ND], d_gd[ND];
    int chg, frc;
    bit cmdb;

    task automatic end_seq(int d);
        for (int m = 0; m < NM; m++) if (m % ND == d) m_cur[m] = m_nxt[m];
        if (d_pn[d] == 0) d_on[d] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < NM; m++) begin
                m_nxt[m] = 2; m_cur[m] = 2; m_lr[m] = 1; m_fr[m] = 0;
            end
            for (int d = 0; d < ND; d++) begin
                d_mode[d] = 0; d_cnt[d] = 0; d_on[d] = 1; d_pn[d] = 1; d_gd[d] = 0;
            end
        end else begin
            for (int d = 0; d < ND; d++) begin
                chg = 0; frc = 0;
                for (int m = 0; m < NM; m++) if (m % ND == d) begin
                    if (m_nxt[m] != m_cur[m]) chg = 1;
                    if (m_fr[m] != 0) frc = 1;
                end
                cmdb = bus_wr && bus_addr == 12'h120 && bus_wdata[d];
                case (d_mode[d])
                    0: if (cmdb) begin
                        if (d_on[d] == 0 && d_pn[d] == 1) d_mode[d] = 1;
                        else if (chg != 0) begin d_mode[d] = 2; d_cnt[d] = TC - 1; end
                        else d_mode[d] = 3;
                    end
                    1: if (d_gd[d] != 0 || frc != 0) begin
                        d_on[d] = 1;
                        if (chg != 0) begin d_mode[d] = 2; d_cnt[d] = TC - 1; end
                        else d_mode[d] = 3;
                    end
                    2: if (d_cnt[d] == 0) begin end_seq(d); d_mode[d] = 0; end
                       else d_cnt[d] = d_cnt[d] - 1;
                    default: begin end_seq(d); d_mode[d] = 0; end
                endcase
            end
            if (bus_wr && bus_addr[1:0] == 0) begin
                if (bus_addr[11:8] == 4'hA && int'(bus_addr[7:2]) < NM) begin
                    m_nxt[bus_addr[7:2]] = int'(bus_wdata[1:0]);
                    m_lr[bus_addr[7:2]]  = int'(bus_wdata[8]);
                    m_fr[bus_addr[7:2]]  = int'(bus_wdata[31]);
                end
                if (bus_addr[11:8] == 4'h3 && int'(bus_addr[7:2]) < ND) begin
                    d_pn[bus_addr[7:2]] = int'(bus_wdata[0]);
                    d_gd[bus_addr[7:2]] = int'(bus_wdata[8]);
                end
            end
        end
    end

    function automatic logic [31:0] mread(logic [11:0] a);
        logic [31:0] r = '0;
        int i = int'(a[7:2]);
        if (a[1:0] != 0) return '0;
        if (a == 12'h070) begin
            for (int d = 0; d < ND; d++) r[d] = (d_mode[d] == 1);
        end else if (a == 12'h128) begin
            for (int d = 0; d < ND; d++) r[d] = (d_mode[d] != 0);
        end else if (a[11:8] == 4'h2 && i < ND) r[0] = (d_on[i] != 0);
        else if (a[11:8] == 4'h3 && i < ND) begin
            r[0] = d_pn[i][0]; r[8] = d_gd[i][0];
        end else if (a[11:8] == 4'h8 && i < NM) begin
            r[1:0] = m_cur[i][1:0]; r[12] = (m_cur[i] == 3);
        end else if (a[11:8] == 4'hA && i < NM) begin
            r[1:0] = m_nxt[i][1:0]; r[8] = m_lr[i][0]; r[31] = m_fr[i][0];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model, between edges
    always @(posedge clk) begin
        #8;
        if (rst_n && !done) begin
            for (int m = 0; m < NM; m++) begin
                chk("R5 clk_en", 32'(mod_clk_en[m]), 32'(m_cur[m] == 3));
                chk("R6 rst_n", 32'(mod_rst_n[m]), 32'(m_lr[m] == 1 && m_cur[m] >= 2));
            end
            for (int d = 0; d < ND; d++) chk("R7 pwr_req", 32'(pwr_req[d]), 32'(d_mode[d] == 1));
            chk("R2 rdata model", bus_rdata, mread(bus_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_exp(string tag, logic [11:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd_exp("R1 mctl0", 12'hA00, 32'h102);
        rd_exp("R1 mstat3", 12'h80C, 32'h2);
        rd_exp("R1 dstat1", 12'h204, 32'h1);
        rd_exp("R1 dctl0", 12'h300, 32'h1);
        rd_exp("R1 busy", 12'h128, 32'h0);
        rd_exp("R1 pend", 12'h070, 32'h0);
        chk("R1 clk_en", 32'(mod_clk_en), 32'h0);
        chk("R1 pwr_req", 32'(pwr_req), 32'h0);

        // R3 control write alone does not move the state; 6-bit field keeps 2 bits
        wr(12'hA00, 32'h13F);
        rd_exp("R3 mctl readback", 12'hA00, 32'h103);
        repeat (3) tick();
        rd_exp("R3 no change before cmd", 12'h800, 32'h2);
        wr(12'h120, 32'h1);
        rd_exp("R4 busy set", 12'h128, 32'h1);
        repeat (3) tick();
        rd_exp("R3 still old at k+3", 12'h800, 32'h2);
        tick();
        rd_exp("R3 R5 new at k+4", 12'h800, 32'h1003);
        rd_exp("R4 busy clear", 12'h128, 32'h0);
        rd_exp("R3 other module kept", 12'h808, 32'h2);
        chk("R5 clk_en0", 32'(mod_clk_en[0]), 32'h1);

        // R4 no-change command
        wr(12'h120, 32'h1);
        rd_exp("R4 one-cycle busy", 12'h128, 32'h1);
        tick();
        rd_exp("R4 one-cycle clear", 12'h128, 32'h0);

        // R10 command to busy domain ignored
        wr(12'hA08, 32'h103);
        wr(12'h120, 32'h1);
        tick();
        wr(12'h120, 32'h1);
        tick();
        tick();
        rd_exp("R10 busy not extended", 12'h128, 32'h0);
        rd_exp("R10 mod2 enabled", 12'h808, 32'h1003);

        // R6 local reset independent of clock
        wr(12'hA00, 32'h003);
        chk("R6 rst low", 32'(mod_rst_n[0]), 32'h0);
        chk("R6 clk still on", 32'(mod_clk_en[0]), 32'h1);
        wr(12'hA00, 32'h103);
        chk("R6 rst released", 32'(mod_rst_n[0]), 32'h1);
        wr(12'hA08, 32'h101);
        wr(12'h120, 32'h1);
        repeat (4) tick();
        rd_exp("R6 sync reset state", 12'h808, 32'h1);
        chk("R6 sync reset holds rst", 32'(mod_rst_n[2]), 32'h0);

        // R9 power down domain 1
        wr(12'h304, 32'h0);
        wr(12'h120, 32'h2);
        tick();
        rd_exp("R9 domain off", 12'h204, 32'h0);

        // R7 power-up handshake
        wr(12'h304, 32'h1);
        wr(12'h120, 32'h2);
        rd_exp("R7 pending set", 12'h070, 32'h2);
        chk("R7 pwr_req", 32'(pwr_req), 32'h2);
        repeat (5) tick();
        rd_exp("R7 still waiting", 12'h128, 32'h2);
        rd_exp("R7 still off", 12'h204, 32'h0);
        wr(12'h304, 32'h101);
        rd_exp("R7 pending until seen", 12'h070, 32'h2);
        tick();
        rd_exp("R7 pending clear", 12'h070, 32'h0);
        rd_exp("R7 domain on", 12'h204, 32'h1);
        tick();
        rd_exp("R7 done", 12'h128, 32'h0);

        // R8 force bypasses power good
        wr(12'h304, 32'h0);
        wr(12'h120, 32'h2);
        tick();
        rd_exp("R8 off again", 12'h204, 32'h0);
        wr(12'hA04, 32'h8000_0103);
        wr(12'h304, 32'h1);
        wr(12'h120, 32'h2);
        rd_exp("R8 waiting", 12'h070, 32'h2);
        tick();
        rd_exp("R8 forced on", 12'h204, 32'h1);
        repeat (3) tick();
        rd_exp("R8 mod1 not yet", 12'h804, 32'h2);
        tick();
        rd_exp("R8 mod1 enabled", 12'h804, 32'h1003);

        // R2 decode: unmapped, misaligned, out-of-range index, read-only
        wr(12'h0FC, 32'hFFFF_FFFF);
        rd_exp("R2 unmapped read", 12'h0FC, 32'h0);
        wr(12'h800, 32'h0);
        rd_exp("R2 status write ignored", 12'h800, 32'h1003);
        wr(12'hA10, 32'h0);
        rd_exp("R2 index beyond mods", 12'hA10, 32'h0);
        rd_exp("R2 mods untouched", 12'hA00, 32'h103);
        rd_exp("R2 dom index beyond", 12'h208, 32'h0);
        rd_exp("R2 misaligned", 12'hA01, 32'h0);
        rd_exp("R2 cmd reads zero", 12'h120, 32'h0);

        tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule